// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Flow-Through Read

This block is a small on-chip static memory whose address, write data, chip selects and write controls are all captured on the rising clock edge. Reads are flow-through: once the address is registered, the selected word comes straight from the array in that same cycle, with no output register. Writes are committed at the following rising edge. The word is built from a parameterised number of byte lanes. A write can store the whole word through a global-write control, or chosen lanes through a byte-write enable qualified by per-lane selects.

A new access starts when the load strobe is low. On that edge the block registers a base address, samples three chip enables and samples the burst ordering. While the load strobe stays high, the advance strobe steps a two-bit burst counter through the four words of the aligned group. The order is either sequential with wrap-around or an XOR ordering. The memory port is modelled as a shared data bus split into an input lane, an output lane and a drive flag. The output lane is driven only on an enabled read cycle, and a deselect takes effect one cycle after it is loaded.

Top module: `sram_flow_top`

## Requirements
- R1: After reset the block is deselected. `rdDrive` is low and `rdData` is zero until a load with all chip enables active.
- R2: A load (`loadN` low) selects the block only when `ce1N` is 0, `ce2` is 1 and `ce3N` is 0. With any other combination, no read drives the bus in the following cycle.
- R3: With `gwN` low in a cycle, the next rising edge stores every byte lane of `wrData`, whatever `bweN` and `bwN` are.
- R4: With `gwN` high, lane b (bits b*8+7 to b*8) is stored only when `bweN` is low and `bwN[b]` is low. All other lanes keep their previous contents.
- R5: A selected cycle with `gwN` high and either `bweN` high or `bwN` all ones is a read and leaves the array unchanged.
- R6: In a read cycle, `rdData` equals the array word at the address registered at the start of that cycle. This includes a word written by the previous cycle.
- R7: `rdDrive` equals "read cycle and `oeN` low", without a register in between. It is low in every write cycle. `rdData` is zero whenever `rdDrive` is low.
- R8: With `burstXor` low at the load, each cycle with `loadN` high and `advN` low moves the low two word-address bits to (base + count) mod 4. The upper address bits stay fixed.
- R9: With `burstXor` high at the load, the low two word-address bits follow base XOR count as the count steps.
- R10: A cycle with both `loadN` and `advN` high keeps the word address unchanged.
- R11: A load with an inactive chip-enable combination stops the bus from being driven in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oeN` are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadN | input | 1 | Active low; starts an access at `addr` and samples the chip enables |
| advN | input | 1 | Active low; advances the burst counter when not loading |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| addr | input | AW | Word address, sampled on a load |
| burstXor | input | 1 | Burst order sampled on a load: 0 sequential, 1 XOR |
| gwN | input | 1 | Active-low global write of all lanes |
| bweN | input | 1 | Active-low byte-write enable |
| bwN | input | NB | Active-low per-lane byte selects |
| wrData | input | NB*8 | Write data lane of the shared bus |
| oeN | input | 1 | Active-low output enable, asynchronous |
| rdData | output | NB*8 | Read data lane of the shared bus, zero when not driven |
| rdDrive | output | 1 | High while the block drives the bus |

## Verification
The assertions assume the burst order changes only through a load, so `burstXor` between loads has no effect. They also assume reset is held for at least one edge before any load, so the held address and selection start from known values. The stimulus fills every word with a global write before any read, so every compared read has a defined reference value. It changes `oeN` only at the falling edge, so the combinational drive flag is stable when sampled.

// File: rtl/sram_flow_pkg.sv
package sram_flow_pkg;
  localparam int BURST_W = 2;

  // strobes from control to datapath for the current (registered) cycle
  typedef struct packed {
    logic active;
    logic doWrite;
    logic doRead;
  } strobeT;
endpackage

// File: rtl/sram_flow_ctrl.sv
module sram_flow_ctrl
  import sram_flow_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadN,
  input  logic          advN,
  input  logic          ce1N,
  input  logic          ce2,
  input  logic          ce3N,
  input  logic [AW-1:0] addr,
  input  logic          burstXor,
  input  logic          gwN,
  input  logic          bweN,
  input  logic [NB-1:0] bwN,
  output strobeT        strobes,
  output logic [AW-1:0] wordAddr,
  output logic [NB-1:0] wrMask
);
  localparam int HI_W = AW - BURST_W;

  logic               actReg;
  logic [AW-1:0]      baseReg;
  logic [BURST_W-1:0] cntReg;
  logic               xorReg;
  logic [NB-1:0]      maskReg;
  logic [NB-1:0]      maskIn;
  logic               selIn;
  logic [BURST_W-1:0] lowBits;

  assign selIn = ~ce1N & ce2 & ~ce3N;

  always_comb begin
    if (!gwN)       maskIn = '1;
    else if (!bweN) maskIn = ~bwN;
    else            maskIn = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actReg  <= 1'b0;
      baseReg <= '0;
      cntReg  <= '0;
      xorReg  <= 1'b0;
      maskReg <= '0;
    end else begin
      if (!loadN) begin
        actReg  <= selIn;
        baseReg <= addr;
        cntReg  <= '0;
        xorReg  <= burstXor;
      end else if (!advN) begin
        cntReg <= cntReg + 1'b1;
      end
      maskReg <= maskIn;
    end
  end

  always_comb begin
    if (xorReg) lowBits = baseReg[BURST_W-1:0] ^ cntReg;
    else        lowBits = baseReg[BURST_W-1:0] + cntReg;
  end

  assign wordAddr        = {baseReg[AW-1:BURST_W], lowBits};
  assign wrMask          = maskReg;
  assign strobes.active  = actReg;
  assign strobes.doWrite = actReg & (|maskReg);
  assign strobes.doRead  = actReg & ~(|maskReg);

  logic unusedHi;
  assign unusedHi = ^{HI_W[0]};

  AST_DESELECT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && !selIn) |=> !strobes.active); // R11
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && advN) |=> $stable(wordAddr)); // R10
  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    !gwN |=> (wrMask == {NB{1'b1}})); // R3
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !advN && !xorReg) |=>
      (wordAddr[BURST_W-1:0] == $past(wordAddr[BURST_W-1:0]) + 2'd1)); // R8
endmodule

// File: rtl/sram_flow_datapath.sv
module sram_flow_datapath
  import sram_flow_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobes,
  input  logic [AW-1:0]    wordAddr,
  input  logic [NB-1:0]    wrMask,
  input  logic [NB*BW-1:0] wrData,
  input  logic             oeN,
  output logic [NB*BW-1:0] rdData,
  output logic             rdDrive
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = NB * BW;

  logic [DW-1:0] dataReg;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) dataReg <= '0;
    else       dataReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobes.doWrite) begin
      for (int b = 0; b < NB; b++) begin
        if (wrMask[b]) mem[wordAddr][b*BW +: BW] <= dataReg[b*BW +: BW];
      end
    end
  end

  assign rdDrive = strobes.doRead & ~oeN;
  assign rdData  = rdDrive ? mem[wordAddr] : '0;

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doWrite |-> !rdDrive); // R7
  AST_FULL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doWrite && wrMask == {NB{1'b1}}) |=>
      (mem[$past(wordAddr)] == $past(dataReg))); // R3
endmodule

// File: rtl/sram_flow_top.sv
module sram_flow_top
  import sram_flow_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            loadN,
  input  logic            advN,
  input  logic            ce1N,
  input  logic            ce2,
  input  logic            ce3N,
  input  logic [AW-1:0]   addr,
  input  logic            burstXor,
  input  logic            gwN,
  input  logic            bweN,
  input  logic [NB-1:0]   bwN,
  input  logic [NB*8-1:0] wrData,
  input  logic            oeN,
  output logic [NB*8-1:0] rdData,
  output logic            rdDrive
);
  strobeT        strobes;
  logic [AW-1:0] wordAddr;
  logic [NB-1:0] wrMask;

  sram_flow_ctrl #(.AW(AW), .NB(NB)) uCtrl (
    .clk(clk), .rstN(rstN), .loadN(loadN), .advN(advN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .addr(addr),
    .burstXor(burstXor), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .strobes(strobes), .wordAddr(wordAddr), .wrMask(wrMask)
  );

  sram_flow_datapath #(.AW(AW), .NB(NB), .BW(8)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordAddr(wordAddr),
    .wrMask(wrMask), .wrData(wrData), .oeN(oeN),
    .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: tb/tb_sram_flow_top.sv
module tb_sram_flow_top;
  localparam int CLK_P = 10;

  logic clk = 0, rstN = 0;
  logic loadN = 1, advN = 1, ce1N = 1, ce2 = 0, ce3N = 1, burstXor = 0;
  logic [3:0] addr = 0;
  logic gwN = 1, bweN = 1, oeN = 0;
  logic [3:0] bwN = 4'hF;
  logic [31:0] wrData = 0;
  logic [31:0] rdData;
  logic rdDrive;

  int total = 0, fails = 0;
  bit done = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [31:0] refMem [16];
  bit mAct = 0, mXor = 0;
  int mBase = 0, mCnt = 0;
  logic [3:0] mMask = 0;
  logic [31:0] mData = 0;

  sram_flow_top dut (
    .clk(clk), .rstN(rstN), .loadN(loadN), .advN(advN), .ce1N(ce1N),
    .ce2(ce2), .ce3N(ce3N), .addr(addr), .burstXor(burstXor), .gwN(gwN),
    .bweN(bweN), .bwN(bwN), .wrData(wrData), .oeN(oeN),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mAddr();
    int lo;
    lo = mXor ? ((mBase & 3) ^ mCnt) : (((mBase & 3) + mCnt) & 3);
    return (mBase & 12) | lo;
  endfunction

  // one clock: model update at the edge, compare just after it
  task automatic tick();
    bit expDrive;
    @(posedge clk);
    if (rstN) begin
      if (mAct && mMask != 0)
        for (int b = 0; b < 4; b++)
          if (mMask[b]) refMem[mAddr()][b*8 +: 8] = mData[b*8 +: 8];
      if (!loadN) begin
        mAct = (!ce1N && ce2 && !ce3N); mBase = addr; mCnt = 0; mXor = burstXor;
      end else if (!advN) mCnt = (mCnt + 1) & 3;
      mMask = !gwN ? 4'hF : (!bweN ? ~bwN : 4'h0);
      mData = wrData;
    end
    #2;
    expDrive = mAct && mMask == 0 && !oeN;
    chk(curReq, {31'd0, rdDrive}, {31'd0, expDrive});
    chk(curReq, rdData, expDrive ? refMem[mAddr()] : 32'd0);
    @(negedge clk);
  endtask

  task automatic selOn(); ce1N = 0; ce2 = 1; ce3N = 0; endtask
  task automatic quiet(); loadN = 1; advN = 1; gwN = 1; bweN = 1; bwN = 4'hF; endtask
  task automatic ldRead(int a, bit x);
    quiet(); selOn(); loadN = 0; addr = 4'(a); burstXor = x;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    curReq = "R1";
    chk("R1", {31'd0, rdDrive}, 32'd0);
    chk("R1", rdData, 32'd0);
    rstN = 1;
    quiet(); tick(); tick();

    // R3: fill every word with a global write while byte selects disagree
    curReq = "R3";
    for (int a = 0; a < 16; a++) begin
      quiet(); selOn(); loadN = 0; addr = 4'(a); gwN = 0; bweN = a[0]; bwN = 4'(a);
      wrData = 32'hA5000000 + a * 32'h00010203;
      tick();
    end
    quiet(); tick();

    // R6: read each word back, flow-through
    curReq = "R6";
    for (int a = 0; a < 16; a++) begin ldRead(a, 0); tick(); end

    // R4: byte-lane writes with various selects
    curReq = "R4";
    for (int p = 0; p < 16; p++) begin
      quiet(); selOn(); loadN = 0; addr = 4'(p); bweN = 0; bwN = 4'(p);
      wrData = 32'h11223344 ^ (p * 32'h01010101);
      tick();
      ldRead(p, 0); tick();
    end

    // R5: selects low but enable high -> read, no change
    curReq = "R5";
    quiet(); selOn(); loadN = 0; addr = 4'd5; bweN = 1; bwN = 4'h0; wrData = 32'hDEADBEEF;
    tick();
    ldRead(5, 0); tick();

    // R6: write then read same word in the next cycle
    curReq = "R6";
    quiet(); selOn(); loadN = 0; addr = 4'd9; gwN = 0; wrData = 32'hCAFEF00D;
    tick();
    ldRead(9, 0); tick();
    chk("R6", rdData, 32'hCAFEF00D);

    // R7: output enable high blocks drive, then low restores it
    curReq = "R7";
    ldRead(3, 0); oeN = 1; tick();
    quiet(); oeN = 0; tick();

    // R2: every inactive combination
    curReq = "R2";
    for (int c = 0; c < 8; c++) begin
      ldRead(7, 0); ce1N = c[0]; ce2 = c[1]; ce3N = c[2];
      tick();
    end

    // R11: selected read, then deselecting load
    curReq = "R11";
    ldRead(2, 0); tick();
    ldRead(2, 0); ce2 = 0; tick();
    chk("R11", {31'd0, rdDrive}, 32'd0);

    // R8: sequential burst from base 6 -> 6,7,4,5
    curReq = "R8";
    ldRead(6, 0); tick();
    chk("R8", rdData, refMem[6]);
    quiet(); advN = 0; tick(); chk("R8", rdData, refMem[7]);
    tick(); chk("R8", rdData, refMem[4]);
    tick(); chk("R8", rdData, refMem[5]);

    // R10: suspend holds address
    curReq = "R10";
    quiet(); tick(); chk("R10", rdData, refMem[5]);

    // R9: XOR burst from base 13 -> 13,12,15,14
    curReq = "R9";
    ldRead(13, 1); tick();
    chk("R9", rdData, refMem[13]);
    quiet(); advN = 0; tick(); chk("R9", rdData, refMem[12]);
    tick(); chk("R9", rdData, refMem[15]);
    tick(); chk("R9", rdData, refMem[14]);

    // R4: byte write inside a burst
    curReq = "R4";
    ldRead(8, 0); tick();
    quiet(); advN = 0; bweN = 0; bwN = 4'b1010; wrData = 32'h0BADCAFE; tick();
    ldRead(9, 0); tick();
    quiet(); tick();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule